// File: doc/BRIEF.md
# Wander-Absorbing Elastic Frame Buffer

This block sits between a line frame, paced by a recovered clock, and a system frame, paced by an external bit clock and frame sync. The line side writes one frame's channel content at a time: two 8-bit bearer octets and a 4-bit signalling nibble. The system side reads whole frames. Three frame slots sit between the two sides, so the two frame timings can start with any relative alignment and drift against each other without losing data. A frame is written and read as one unit, so a reader never sees a half-written frame.

Wander is measured in ticks of a 512 kHz reference strobe. One system frame is 64 ticks. The first read transfer sets the baseline, which is zero wander. After that, each read transfer adds the ticks counted since the previous transfer, minus 64, to the wander. When the magnitude of the wander reaches 13 ticks (about 25 µs), a slip is declared. The read pointer is moved to the middle slot and the baseline is reset. A warning then goes out on the next two control/indication frames. In loop mode the two timings share one source, so no slip is ever reported.

The write side is a valid/ready stream that never applies back-pressure: `wr_ready` is always high and every `wr_valid` cycle stores a frame. The read side is a valid/ready stream in which `rd_ready` is the system frame strobe. A frame transfers in a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` while `rd_valid` is low is ignored. Once `rd_valid` is high it stays high, and the read data stay stable until the next transfer or slip.

Top module: `elastic_frame_buffer`

## Requirements
- R1: After reset, `rd_valid` and `slip_warn` are low and `wr_ready` is high.
- R2: `wr_ready` is always high. Each `wr_valid` cycle stores {B1, B2, D} as one unit into the next of three slots, in circular order starting at slot 0. `rd_valid` rises after the second stored frame and never falls afterwards.
- R3: `rd_b1`/`rd_b2`/`rd_d` present the slot at the read pointer, which starts at slot 0. A transfer (`rd_valid` and `rd_ready`) advances the read pointer circularly. `rd_ready` while `rd_valid` is low has no effect.
- R4: The first transfer sets the wander to zero, whatever the ticks counted before it.
- R5: At every later transfer, the wander is incremented by the number of `ref_tick` cycles since the previous transfer, minus 64. A tick in the transfer cycle itself is included.
- R6: If the new wander has magnitude of 13 or more, a slip occurs. The wander becomes 0, and the read pointer moves to slot (w+1) mod 3, where w is the next slot to be written.
- R7: On each `ci_fs` cycle, `slip_warn` becomes 1 if a warning repetition is pending, else 0, and one repetition is consumed. Every slip arms two repetitions, which restarts the count at two. `slip_warn` changes only after `ci_fs` cycles.
- R8: While `loop_mode` is high, no slip occurs and each transfer resets the wander to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per 512 kHz reference period |
| loop_mode | input | 1 | Shared-source test loop; suppresses slips |
| wr_valid | input | 1 | Line frame content present |
| wr_ready | output | 1 | Always high; writes are never stalled |
| wr_b1 | input | 8 | First bearer octet to write |
| wr_b2 | input | 8 | Second bearer octet to write |
| wr_d | input | 4 | Signalling bits to write |
| rd_valid | output | 1 | A frame is available to read |
| rd_ready | input | 1 | System frame strobe; takes a frame when `rd_valid` is high |
| rd_b1 | output | 8 | First bearer octet read |
| rd_b2 | output | 8 | Second bearer octet read |
| rd_d | output | 4 | Signalling bits read |
| ci_fs | input | 1 | Control/indication frame start strobe |
| slip_warn | output | 1 | Slip warning for the current control/indication frame |

## Verification
On every cycle, the assertions check the following: the slot pointers stay in range; `rd_valid` never falls once raised; every transfer leaves the wander inside the ±13 window; a slip or a loop-mode transfer clears the wander; a slip arms exactly two repetitions; and `slip_warn` moves only after a control frame strobe. Only the bench scenarios can show the rest. These are the data order through the three slots, the frame at which a given drift produces a slip, the baseline being independent of the start-up alignment, the recentred read position after a slip, and the two-frame shape of the warning, including the continuous warning when slips come on every frame.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int CH_W  = 8;
  localparam int SIG_W = 4;

  typedef struct packed {
    logic [CH_W-1:0]  b1;
    logic [CH_W-1:0]  b2;
    logic [SIG_W-1:0] d;
  } frame_t;
endpackage

// File: rtl/ebuf_slots.sv
module ebuf_slots
  import ebuf_pkg::*;
#(
  parameter int SLOTS = 3,
  parameter int PRIME = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  frame_t wr_frame,
  input  logic   rd_fire,
  input  logic   recentre,
  output frame_t rd_frame,
  output logic   rd_valid
);
  localparam int PW     = $clog2(SLOTS);
  localparam int CW     = $clog2(PRIME + 1);
  localparam int MIDOFF = SLOTS - 1 - (SLOTS - 1) / 2;

  frame_t        mem [SLOTS];
  logic [PW-1:0] wptr, rptr, wptr_nx, rptr_nx;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input int n);
    int s;
    s = (int'(p) + n) % SLOTS;
    return s[PW-1:0];
  endfunction

  always_comb begin
    wptr_nx = wr_en ? step(wptr, 1) : wptr;
    if (recentre)     rptr_nx = step(wptr_nx, MIDOFF);
    else if (rd_fire) rptr_nx = step(rptr, 1);
    else              rptr_nx = rptr;
  end

  // one whole frame per slot, written in a single cycle
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                            mem[g] <= '0;
      else if (wr_en && wptr == PW'(g))      mem[g] <= wr_frame;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      rd_valid <= 1'b0;
    end else begin
      wptr <= wptr_nx;
      rptr <= rptr_nx;
      if (wr_en && !rd_valid) begin
        fill <= fill + 1'b1;
        if (fill == CW'(PRIME - 1)) rd_valid <= 1'b1;
      end
    end
  end

  assign rd_frame = mem[rptr];

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wptr) < SLOTS) && (int'(rptr) < SLOTS));
  assert_valid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_valid);
endmodule

// File: rtl/ebuf_wander.sv
module ebuf_wander #(
  parameter int TPF   = 64,
  parameter int LIMIT = 13,
  parameter int LAG_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic primed,
  input  logic rd_fire,
  input  logic loop_mode,
  output logic slip
);
  localparam int LAG_MAX = (1 << (LAG_W - 1)) - 1;

  logic signed [LAG_W-1:0] lag;
  logic                    based;
  int                      lag_sum;

  always_comb begin
    lag_sum = int'(lag) + (ref_tick ? 1 : 0) - TPF;
    slip    = rd_fire && based && !loop_mode &&
              ((lag_sum >= LIMIT) || (lag_sum <= -LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lag   <= '0;
      based <= 1'b0;
    end else if (rd_fire) begin
      based <= 1'b1;
      if (!based || loop_mode || slip) lag <= '0;
      else                             lag <= LAG_W'(lag_sum);
    end else if (primed && ref_tick && (int'(lag) != LAG_MAX)) begin
      lag <= lag + 1'b1;
    end
  end

  assert_slip_rebase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> (lag == '0));
  assert_lag_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ((int'(lag) < LIMIT) && (int'(lag) > -LIMIT)));
  assert_loop_rebase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && rd_fire) |=> (lag == '0));
endmodule

// File: rtl/ebuf_warn.sv
module ebuf_warn #(
  parameter int REPEAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slip,
  input  logic ci_fs,
  output logic slip_warn
);
  localparam int RW = $clog2(REPEAT + 1);

  logic [RW-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      slip_warn <= 1'b0;
    end else begin
      if (ci_fs) slip_warn <= (pend != '0);
      if (slip)                        pend <= RW'(REPEAT);
      else if (ci_fs && pend != '0)    pend <= pend - 1'b1;
    end
  end

  assert_warn_on_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ci_fs |=> $stable(slip_warn));
  assert_arm_twice_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> (pend == RW'(REPEAT)));
endmodule

// File: rtl/elastic_frame_buffer.sv
module elastic_frame_buffer
  import ebuf_pkg::*;
#(
  parameter int SLOTS  = 3,
  parameter int PRIME  = 2,
  parameter int TPF    = 64,
  parameter int LIMIT  = 13,
  parameter int LAG_W  = 16,
  parameter int REPEAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             loop_mode,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CH_W-1:0]  wr_b1,
  input  logic [CH_W-1:0]  wr_b2,
  input  logic [SIG_W-1:0] wr_d,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [CH_W-1:0]  rd_b1,
  output logic [CH_W-1:0]  rd_b2,
  output logic [SIG_W-1:0] rd_d,
  input  logic             ci_fs,
  output logic             slip_warn
);
  frame_t in_frame, out_frame;
  logic   rd_fire, slip;

  assign wr_ready = 1'b1;
  assign in_frame = '{b1: wr_b1, b2: wr_b2, d: wr_d};
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_b1    = out_frame.b1;
  assign rd_b2    = out_frame.b2;
  assign rd_d     = out_frame.d;

  ebuf_slots #(.SLOTS(SLOTS), .PRIME(PRIME)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid), .wr_frame(in_frame),
    .rd_fire(rd_fire), .recentre(slip), .rd_frame(out_frame), .rd_valid(rd_valid)
  );

  ebuf_wander #(.TPF(TPF), .LIMIT(LIMIT), .LAG_W(LAG_W)) u_wander (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .primed(rd_valid),
    .rd_fire(rd_fire), .loop_mode(loop_mode), .slip(slip)
  );

  ebuf_warn #(.REPEAT(REPEAT)) u_warn (
    .clk(clk), .rst_n(rst_n), .slip(slip), .ci_fs(ci_fs), .slip_warn(slip_warn)
  );
endmodule

// File: tb/elastic_frame_buffer_test.sv
module elastic_frame_buffer_test;
  logic clk = 1'b0;
  logic rst_n, ref_tick, loop_mode, wr_valid, rd_ready, ci_fs;
  logic [7:0] wr_b1, wr_b2, rd_b1, rd_b2;
  logic [3:0] wr_d, rd_d;
  logic wr_ready, rd_valid, slip_warn;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [19:0] mmem [3];
  int wp, rp, wcount, tk, lag, pend, rises;
  bit based, prev_warn;

  always #2 clk = ~clk;

  elastic_frame_buffer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .loop_mode(loop_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_b1(wr_b1), .wr_b2(wr_b2),
    .wr_d(wr_d), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_b1(rd_b1),
    .rd_b2(rd_b2), .rd_d(rd_d), .ci_fs(ci_fs), .slip_warn(slip_warn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pat(input int seq);
    logic [7:0] a, b;
    a = 8'((seq * 37 + 5) & 255);
    b = 8'((seq * 11 + 1) & 255);
    return {a, b, 4'(seq & 15)};
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; ref_tick = 0; wr_valid = 0; rd_ready = 0; ci_fs = 0;
    wr_b1 = 0; wr_b2 = 0; wr_d = 0;
    cyc(); cyc();
    rst_n = 1;
    wp = 0; rp = 0; wcount = 0; tk = 0; lag = 0; pend = 0; rises = 0;
    based = 0; prev_warn = 0;
    for (int i = 0; i < 3; i++) mmem[i] = '0;
    check(!rd_valid && !slip_warn && wr_ready, "R1 reset state",
          {rd_valid, slip_warn, wr_ready}, 3'b001);
  endtask

  // one system frame: optional write, nt reference ticks, read strobe, C/I frame
  task automatic frame(input int nt);
    bit fire, slip, ew;
    logic [19:0] d;
    d = pat(wcount);
    wr_valid = 1; {wr_b1, wr_b2, wr_d} = d;
    cyc();
    wr_valid = 0;
    mmem[wp] = d; wp = (wp + 1) % 3; wcount++;
    check(wr_ready, "R2 wr_ready high", wr_ready, 1);
    check(rd_valid == (wcount >= 2), "R2 rd_valid after two frames", rd_valid, wcount >= 2);
    for (int i = 0; i < nt; i++) begin
      ref_tick = 1; cyc();
    end
    ref_tick = 0;
    tk += nt;
    fire = (wcount >= 2);
    if (fire)
      check({rd_b1, rd_b2, rd_d} == mmem[rp], "R3 read data at read pointer",
            {rd_b1, rd_b2, rd_d}, mmem[rp]);
    rd_ready = 1; cyc(); rd_ready = 0;
    slip = 0;
    if (fire) begin
      if (!based) begin
        based = 1; lag = 0; rp = (rp + 1) % 3;           // R4 baseline
      end else begin
        lag += tk - 64;                                   // R5
        if (loop_mode) begin
          lag = 0; rp = (rp + 1) % 3;                     // R8
        end else if (lag >= 13 || lag <= -13) begin
          slip = 1; lag = 0; rp = (wp + 1) % 3;           // R6
        end else rp = (rp + 1) % 3;
      end
      tk = 0;
    end
    check(slip_warn == prev_warn, "R7 warn stable outside C/I strobe", slip_warn, prev_warn);
    if (slip) pend = 2;
    ci_fs = 1; cyc(); ci_fs = 0;
    ew = (pend > 0);
    if (pend > 0) pend--;
    check(slip_warn == ew, "R7 warning per C/I frame", slip_warn, ew);
    if (slip_warn && !prev_warn) rises++;
    prev_warn = slip_warn;
  endtask

  initial begin
    int dl [9] = '{-13, -3, -2, -1, 0, 1, 2, 3, 13};
    loop_mode = 0;
    do_reset();
    // R3: read strobe before valid is ignored; first transfer shows frame 0
    ref_tick = 0; rd_ready = 1; cyc(); rd_ready = 0;
    check(!rd_valid && {rd_b1, rd_b2, rd_d} == 20'h0, "R3 strobe without valid ignored",
          rd_valid, 0);

    // R5/R6: drift sweep, counting warning episodes arithmetically
    foreach (dl[k]) begin
      int d, a, per, exp_r;
      d = dl[k];
      do_reset();
      for (int f = 0; f < 22; f++) frame(64 + d);
      a = (d < 0) ? -d : d;
      if (a == 0) exp_r = 0;
      else begin
        per = (13 + a - 1) / a;
        exp_r = (per == 1) ? 1 : 20 / per;
      end
      check(rises == exp_r, $sformatf("R6 warning episodes drift %0d", d), rises, exp_r);
    end

    // R4: uneven start-up alignment, then steady frames: no slip
    do_reset();
    frame(10); frame(40);
    for (int f = 0; f < 12; f++) frame(64);
    check(rises == 0, "R4 baseline ignores start-up alignment", rises, 0);

    // R8: loop mode with heavy drift, then normal steady frames
    do_reset();
    loop_mode = 1;
    for (int f = 0; f < 22; f++) frame(67);
    loop_mode = 0;
    for (int f = 0; f < 6; f++) frame(64);
    check(rises == 0, "R8 no warning in loop mode", rises, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule